// File: doc/BRIEF.md
# Reference Clock Readiness Gate

This block watches an external reference clock from a separate control clock that never stops. It decides whether the reference is running and has produced enough pulses to be trusted. A pulse counter in the reference domain starts from zero after each detected stop. It saturates at a threshold, and its completion is carried back to the control domain. While the count is incomplete, three level hold-off outputs stall the power-management logic that owns the matching requests: the release of the global reset, the release of the secondary reset when leaving the deepest sleep state, and the entry into the fully-on state from a lighter sleep state.

The reference clock may stop in any sleep state. Each stop is detected by a timeout on a toggle bit that the reference domain flips on every edge. A detected stop drops readiness at once and forces a fresh count. A stop detected while in the fully-on state sets a sticky error flag. The interface is plain control and status: no data flows through it, so there is no valid/ready handshake.

Power states on `pwr_state` are encoded as 0 = fully on (D0), 1 = D1, 2 = D2, 3 = D3 hot, 4 = D3 cold. Codes 5 to 7 are treated as states with no special rule.

Top module: `refclk_ready_gate`

## Requirements
- R1: After reset, `ref_ready` is 0, `clk_stopped` is 1 and `d0_stop_err` is 0.
- R2: `ref_ready` rises only after at least `PULSES` rising edges of `ref_clk` have occurred since the latest stop detection (or since reset).
- R3: With `ref_clk` running continuously after a stop, `ref_ready` rises within `PULSES`+10 rising edges of `ref_clk`.
- R4: After the last rising edge of `ref_clk`, `clk_stopped` rises no earlier than `STOP_CYCLES` and no later than `STOP_CYCLES`+4 control cycles, and `ref_ready` is 0 from that cycle on.
- R5: When `ref_clk` resumes, `clk_stopped` falls within 5 control cycles of its first rising edge.
- R6: `grst_hold` equals `grst_rel_req` AND NOT `ref_ready`, in every power state.
- R7: `sec_rst_hold` is `sec_rst_rel_req` AND NOT `ref_ready` while `pwr_state` is 4 (D3 cold), and 0 in every other state.
- R8: `d0_entry_hold` is `d0_entry_req` AND NOT `ref_ready` while `pwr_state` is 1, 2 or 3, and 0 in every other state.
- R9: A stop detected while `pwr_state` is 0 sets `d0_stop_err`.
- R10: A stop detected while `pwr_state` is 1 to 7 leaves `d0_stop_err` unchanged.
- R11: `d0_stop_err` stays set until the next reset, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Always-running control clock |
| ctl_rst_n | input | 1 | Active-low reset, asynchronous assertion, for both domains |
| ref_clk | input | 1 | Monitored reference clock, may stop |
| pwr_state | input | 3 | Current power state (0 D0, 1 D1, 2 D2, 3 D3 hot, 4 D3 cold) |
| grst_rel_req | input | 1 | Global reset release is pending |
| sec_rst_rel_req | input | 1 | Secondary reset release is pending |
| d0_entry_req | input | 1 | Entry into D0 is pending |
| ref_ready | output | 1 | Reference has been running for a full fresh count |
| clk_stopped | output | 1 | No reference activity seen within the timeout |
| d0_stop_err | output | 1 | Sticky: reference stopped while in D0 |
| grst_hold | output | 1 | Hold off the global reset release |
| sec_rst_hold | output | 1 | Hold off the secondary reset release |
| d0_entry_hold | output | 1 | Hold off entry into D0 |

## Verification
Two functions can act in the same control cycle. Stop detection drops readiness, while the error flag decides whether that stop counts as a fault in the current power state. The bench provokes this by ending every burst with a silent reference while sweeping all eight power-state codes. It judges that the cycle in which `clk_stopped` rises also shows `ref_ready` low, and that the error flag changed only for state 0. A second coincidence is the hold-off outputs being re-evaluated in the very cycle that readiness rises or falls. The bench compares all three holds against requests and observed readiness in every cycle of the sweep, across request patterns that vary with burst length.

// File: rtl/refclk_gate_pkg.sv
package refclk_gate_pkg;

  typedef enum logic [2:0] {
    PS_D0     = 3'd0,
    PS_D1     = 3'd1,
    PS_D2     = 3'd2,
    PS_D3HOT  = 3'd3,
    PS_D3COLD = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    GS_STOPPED = 2'd0,
    GS_COUNT   = 2'd1,
    GS_READY   = 2'd2
  } gate_state_e;

  // light sleep states from which D0 entry waits on the reference
  function automatic logic is_light_sleep(input logic [2:0] ps);
    return (ps == PS_D1) || (ps == PS_D2) || (ps == PS_D3HOT);
  endfunction

endpackage

// File: rtl/refclk_sync_bits.sv
module refclk_sync_bits #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/refclk_pulse_count.sv
module refclk_pulse_count #(
  parameter int PULSES = 10,
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic clr_req,   // from control domain, level
  output logic done,      // full count reached since last clear
  output logic clr_ack,   // clear seen and applied
  output logic tgl        // flips on every reference edge
);

  localparam int CW = $clog2(PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

  logic          clr_s;
  logic [CW-1:0] cnt;

  refclk_sync_bits #(.STAGES(STAGES), .WIDTH(1)) u_clr_sync (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .d    (clr_req),
    .q    (clr_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      done    <= 1'b0;
      clr_ack <= 1'b0;
      tgl     <= 1'b0;
    end else begin
      tgl     <= ~tgl;
      clr_ack <= clr_s;          // moves on the same edge that zeroes done
      if (clr_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (!done) begin
        cnt  <= cnt + 1'b1;
        done <= (cnt == LAST);
      end
    end
  end

endmodule

// File: rtl/refclk_activity_mon.sv
module refclk_activity_mon #(
  parameter int STOP_CYCLES = 16,
  parameter int STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_async,
  output logic active,
  output logic stop_evt     // high in the cycle before active falls
);

  localparam int IW = (STOP_CYCLES > 2) ? $clog2(STOP_CYCLES) : 1;
  localparam logic [IW-1:0] IDLE_MAX = IW'(STOP_CYCLES - 1);

  logic          tgl_s;
  logic          tgl_prev;
  logic          seen_edge;
  logic [IW-1:0] idle;

  refclk_sync_bits #(.STAGES(STAGES), .WIDTH(1)) u_tgl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tgl_async),
    .q    (tgl_s)
  );

  assign seen_edge = tgl_s ^ tgl_prev;
  assign stop_evt  = active && !seen_edge && (idle == IDLE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev <= 1'b0;
      idle     <= '0;
      active   <= 1'b0;
    end else begin
      tgl_prev <= tgl_s;
      if (seen_edge) begin
        idle   <= '0;
        active <= 1'b1;
      end else begin
        if (idle != IDLE_MAX) idle <= idle + 1'b1;
        if (stop_evt) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/refclk_ready_gate.sv
module refclk_ready_gate
  import refclk_gate_pkg::*;
#(
  parameter int PULSES      = 10,
  parameter int STOP_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ctl_clk,
  input  logic       ctl_rst_n,
  input  logic       ref_clk,
  input  logic [2:0] pwr_state,
  input  logic       grst_rel_req,
  input  logic       sec_rst_rel_req,
  input  logic       d0_entry_req,
  output logic       ref_ready,
  output logic       clk_stopped,
  output logic       d0_stop_err,
  output logic       grst_hold,
  output logic       sec_rst_hold,
  output logic       d0_entry_hold
);

  logic        clr_q;
  logic        ref_done;
  logic        ref_ack;
  logic        ref_tgl;
  logic [1:0]  back_s;
  logic        done_s;
  logic        ack_s;
  logic        active;
  logic        stop_evt;
  gate_state_e st_q, st_d;

  // reference domain: fresh pulse count after every clear
  refclk_pulse_count #(.PULSES(PULSES), .STAGES(SYNC_STAGES)) u_cnt (
    .ref_clk(ref_clk),
    .rst_n  (ctl_rst_n),
    .clr_req(clr_q),
    .done   (ref_done),
    .clr_ack(ref_ack),
    .tgl    (ref_tgl)
  );

  // control domain: activity timeout on the toggle bit
  refclk_activity_mon #(.STOP_CYCLES(STOP_CYCLES), .STAGES(SYNC_STAGES)) u_mon (
    .clk      (ctl_clk),
    .rst_n    (ctl_rst_n),
    .tgl_async(ref_tgl),
    .active   (active),
    .stop_evt (stop_evt)
  );

  refclk_sync_bits #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_back_sync (
    .clk  (ctl_clk),
    .rst_n(ctl_rst_n),
    .d    ({ref_ack, ref_done}),
    .q    (back_s)
  );

  assign done_s = back_s[0];
  assign ack_s  = back_s[1];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_STOPPED: if (active && ack_s && !stop_evt) st_d = GS_COUNT;
      GS_COUNT: begin
        if (stop_evt)               st_d = GS_STOPPED;
        else if (done_s && !ack_s)  st_d = GS_READY;
      end
      GS_READY:   if (stop_evt) st_d = GS_STOPPED;
      default:    st_d = GS_STOPPED;
    endcase
  end

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      st_q        <= GS_STOPPED;
      clr_q       <= 1'b1;
      d0_stop_err <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= (st_d == GS_STOPPED);
      if (stop_evt && (pwr_state == PS_D0)) d0_stop_err <= 1'b1;
    end
  end

  assign ref_ready     = (st_q == GS_READY);
  assign clk_stopped   = !active;
  assign grst_hold     = grst_rel_req && !ref_ready;
  assign sec_rst_hold  = sec_rst_rel_req && (pwr_state == PS_D3COLD) && !ref_ready;
  assign d0_entry_hold = d0_entry_req && is_light_sleep(pwr_state) && !ref_ready;

endmodule

// File: rtl/refclk_ready_gate_chk.sv
module refclk_ready_gate_chk (
  input logic       ctl_clk,
  input logic       ctl_rst_n,
  input logic [2:0] pwr_state,
  input logic       ref_ready,
  input logic       clk_stopped,
  input logic       d0_stop_err,
  input logic       grst_hold,
  input logic       sec_rst_hold,
  input logic       d0_entry_hold,
  input logic       ack_s
);

  // R4: readiness is gone in the cycle a stop is flagged
  a_r4_ready_drops_on_stop: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $rose(clk_stopped) |-> !ref_ready);

  // R2: readiness never coexists with a stopped reference
  a_r2_ready_needs_clock: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    ref_ready |-> !clk_stopped);

  // R2: the count is accepted only after the clear was released
  a_r2_clear_released: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $rose(ref_ready) |-> !ack_s);

  // R9: the error only appears with a stop seen in D0
  a_r9_err_from_d0_stop: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $rose(d0_stop_err) |-> ($rose(clk_stopped) && ($past(pwr_state) == 3'd0)));

  // R11: the error is sticky
  a_r11_err_sticky: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    d0_stop_err |=> d0_stop_err);

  // R6: no hold-off once ready
  a_r6_no_hold_when_ready: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    ref_ready |-> !(grst_hold || sec_rst_hold || d0_entry_hold));

  // R7: secondary reset hold only in D3 cold
  a_r7_sec_hold_state: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    sec_rst_hold |-> (pwr_state == 3'd4));

  // R8: D0 entry hold only from light sleep
  a_r8_d0_hold_state: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    d0_entry_hold |-> (pwr_state inside {3'd1, 3'd2, 3'd3}));

endmodule

bind refclk_ready_gate refclk_ready_gate_chk u_chk (
  .ctl_clk      (ctl_clk),
  .ctl_rst_n    (ctl_rst_n),
  .pwr_state    (pwr_state),
  .ref_ready    (ref_ready),
  .clk_stopped  (clk_stopped),
  .d0_stop_err  (d0_stop_err),
  .grst_hold    (grst_hold),
  .sec_rst_hold (sec_rst_hold),
  .d0_entry_hold(d0_entry_hold),
  .ack_s        (ack_s)
);

// File: tb/refclk_ready_gate_bench.sv
module refclk_ready_gate_bench;

  localparam int CP          = 10;
  localparam int RHALF       = 13;
  localparam int PULSES      = 10;
  localparam int STOP_CYCLES = 16;

  logic       ctl_clk = 1'b0;
  logic       ctl_rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic [2:0] pwr_state = 3'd0;
  logic       grst_rel_req = 1'b0;
  logic       sec_rst_rel_req = 1'b0;
  logic       d0_entry_req = 1'b0;
  logic       ref_ready, clk_stopped, d0_stop_err;
  logic       grst_hold, sec_rst_hold, d0_entry_hold;

  refclk_ready_gate #(.PULSES(PULSES), .STOP_CYCLES(STOP_CYCLES), .SYNC_STAGES(2)) u_refclk_ready_gate (
    .ctl_clk        (ctl_clk),
    .ctl_rst_n      (ctl_rst_n),
    .ref_clk        (ref_clk),
    .pwr_state      (pwr_state),
    .grst_rel_req   (grst_rel_req),
    .sec_rst_rel_req(sec_rst_rel_req),
    .d0_entry_req   (d0_entry_req),
    .ref_ready      (ref_ready),
    .clk_stopped    (clk_stopped),
    .d0_stop_err    (d0_stop_err),
    .grst_hold      (grst_hold),
    .sec_rst_hold   (sec_rst_hold),
    .d0_entry_hold  (d0_entry_hold)
  );

  always #(CP/2) ctl_clk = ~ctl_clk;

  int     checks = 0;
  int     fails = 0;
  int     total_edges = 0;   // written only by the pulse task
  longint last_edge_t = 0;
  int     base_edges = 0;    // written only by the monitor
  int     ready_rises = 0;
  longint fall_t = 0;
  bit     prev_ready = 1'b0;
  bit     prev_stopped = 1'b1;
  bit     done_flag = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1;
      total_edges++;
      last_edge_t = longint'($time);
      #RHALF;
      ref_clk = 1'b0;
      #RHALF;
    end
  endtask

  // per-cycle monitor, sampled at the falling control edge
  always @(negedge ctl_clk) begin
    if (!ctl_rst_n) begin
      base_edges   <= total_edges;
      prev_ready   <= 1'b0;
      prev_stopped <= 1'b1;
    end else begin
      check(grst_hold == (grst_rel_req && !ref_ready), "R6", grst_hold,
            int'(grst_rel_req && !ref_ready));
      check(sec_rst_hold == (sec_rst_rel_req && pwr_state == 3'd4 && !ref_ready), "R7",
            sec_rst_hold, int'(sec_rst_rel_req && pwr_state == 3'd4 && !ref_ready));
      check(d0_entry_hold == (d0_entry_req && pwr_state >= 3'd1 && pwr_state <= 3'd3 && !ref_ready),
            "R8", d0_entry_hold,
            int'(d0_entry_req && pwr_state >= 3'd1 && pwr_state <= 3'd3 && !ref_ready));
      if (ref_ready && !prev_ready) begin
        ready_rises <= ready_rises + 1;
        check((total_edges - base_edges) >= PULSES, "R2", total_edges - base_edges, PULSES);
      end
      if (clk_stopped && !prev_stopped) base_edges <= total_edges;
      if (!clk_stopped && prev_stopped) fall_t <= longint'($time);
      prev_ready   <= ref_ready;
      prev_stopped <= clk_stopped;
    end
  end

  task automatic wait_stop();
    int cyc;
    for (int i = 0; i < STOP_CYCLES + 40 && !clk_stopped; i++) @(negedge ctl_clk);
    cyc = int'((longint'($time) - last_edge_t) / CP);
    check(clk_stopped && cyc >= STOP_CYCLES && cyc <= STOP_CYCLES + 4, "R4", cyc, STOP_CYCLES);
    check(!ref_ready, "R4", ref_ready, 0);
  endtask

  task automatic check_reset_state();
    @(negedge ctl_clk);
    check(ref_ready == 1'b0, "R1", ref_ready, 0);
    check(clk_stopped == 1'b1, "R1", clk_stopped, 1);
    check(d0_stop_err == 1'b0, "R1", d0_stop_err, 0);
  endtask

  initial begin
    #(CP * 150000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    bit     err_exp;
    int     rr0;
    longint t_first;
    err_exp = 1'b0;
    repeat (5) @(posedge ctl_clk);
    #1 ctl_rst_n = 1'b1;
    check_reset_state();

    // sweep power states (D0 last) and burst lengths
    for (int ps = 7; ps >= 0; ps--) begin
      for (int n = 1; n <= PULSES + 12; n++) begin
        @(posedge ctl_clk);
        #1;
        pwr_state       = 3'(ps);
        grst_rel_req    = n[0];
        sec_rst_rel_req = n[1] ^ ps[0];
        d0_entry_req    = n[2] ^ ps[1];
        rr0     = ready_rises;
        t_first = longint'($time);
        pulses(n);
        repeat (6) @(negedge ctl_clk);
        check(fall_t >= t_first && fall_t - t_first <= 5 * CP, "R5",
              int'(fall_t - t_first), 5 * CP);
        if (n >= PULSES + 10)
          check(ready_rises > rr0, "R3", ready_rises - rr0, 1);
        wait_stop();
        @(negedge ctl_clk);
        if (ps == 0) begin
          check(d0_stop_err == 1'b1, err_exp ? "R11" : "R9", d0_stop_err, 1);
          err_exp = 1'b1;
        end else begin
          check(d0_stop_err == 1'b0, "R10", d0_stop_err, 0);
        end
        repeat (3) @(negedge ctl_clk);
      end
    end

    // reset clears the sticky error
    @(posedge ctl_clk);
    #1 ctl_rst_n = 1'b0;
    repeat (3) @(posedge ctl_clk);
    #1 ctl_rst_n = 1'b1;
    check_reset_state();
    check(d0_stop_err == 1'b0, "R11", d0_stop_err, 0);

    // D3 cold exit: secondary release held until ready, stop is no error
    @(posedge ctl_clk);
    #1;
    pwr_state       = 3'd4;
    sec_rst_rel_req = 1'b1;
    rr0 = ready_rises;
    pulses(PULSES + 12);
    repeat (4) @(negedge ctl_clk);
    check(ready_rises > rr0, "R3", ready_rises - rr0, 1);
    check(sec_rst_hold == 1'b0, "R7", sec_rst_hold, 0);
    wait_stop();
    @(negedge ctl_clk);
    check(d0_stop_err == 1'b0, "R10", d0_stop_err, 0);
    check(sec_rst_hold == 1'b1, "R7", sec_rst_hold, 1);

    done_flag = 1'b1;
    finish_run();
  end

endmodule